// File: doc/BRIEF.md
# Multi-Channel PWM Generator

This block produces up to eight independent pulse-width-modulated outputs, configured over a simple word-wide register bus with separate write and read strobes. Each channel divides the input clock by a power of two. It then counts a programmable number of prescaled ticks per cycle, and holds its output high for a programmable number of ticks at the start of each cycle.

All channel run bits live in one shared word at address zero. Software starts or stops one channel with a read-modify-write of that word. Each channel also owns a private window of three registers: a control word with the divide exponent and a stored configuration flag, a period count and a high-time count. Both counts are written as the desired length minus one. A new period, high time or divider setting is taken up only when the running cycle finishes, so a reconfiguration never produces a shortened pulse.

Top module: `pwmx_top`

## Requirements
- R1: After reset every output is low, read data is zero and every register reads back as zero.
- R2: The run word at byte address 0x000 holds bit n for channel n, reads back its current value, and its bits at or above the channel count read as zero.
- R3: Channel n's window starts at byte address 0x010 + n*0x040; control is at window offset 0x00 (bits [2:0] divide exponent, bit 15 stored flag), period at offset 0x2C (bits [12:0]) and high time at offset 0x30 (bits [12:0]); each reads back the last written value with all other bits zero.
- R4: A write to any other address changes no register and no output, and a read of any other address returns zero.
- R5: A running channel advances its tick counter once every 2^k clocks, k being its divide exponent.
- R6: One output cycle lasts (P+1) ticks, P being the period field.
- R7: The output is high for the first (H+1) ticks of each cycle, H being the high-time field; when H is not less than P the output stays high for the whole cycle.
- R8: While a channel's run bit is 0 its output is low and its counters are held at zero; the clock after the bit is set the output is high at the start of a fresh cycle.
- R9: Period, high-time and divider writes made while a channel runs take effect only at the next cycle boundary.
- R10: Read data appears on the read data port in the clock after the read strobe and is zero in any clock that does not follow a read strobe.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The collision that matters is a register write landing in the same clock as a channel's cycle boundary, where the new period and high time must be captured while the old ones finish the previous cycle. The bench reprograms a running channel at arbitrary points inside its cycle and drops and raises run bits in the middle of a cycle. A behavioural model stepped on every clock judges each output sample, so a load taken one tick early or late shows up as a mismatch at the exact clock where the boundary falls.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

  localparam int DATA_W    = 32;
  localparam int CNT_W     = 13;
  localparam int DIV_W     = 3;
  localparam int PRE_W     = (1 << DIV_W) - 1;
  localparam int CH_BASE   = 16;
  localparam int STRIDE_LG = 6;

  localparam logic [STRIDE_LG-1:0] OFS_CTRL = 6'h00;
  localparam logic [STRIDE_LG-1:0] OFS_PER  = 6'h2C;
  localparam logic [STRIDE_LG-1:0] OFS_THR  = 6'h30;

  localparam int CTRL_FLAG_BIT = 15;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RUN,
    SEL_CTRL,
    SEL_PER,
    SEL_THR
  } pwmx_sel_e;

endpackage

// File: rtl/pwmx_decode.sv
module pwmx_decode
  import pwmx_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WIN_W = ADDR_W - STRIDE_LG
) (
  input  logic [ADDR_W-1:0] addr_i,
  output pwmx_sel_e         sel_o,
  output logic [CH_W-1:0]   ch_o
);

  logic [ADDR_W-1:0]    off;
  logic [WIN_W-1:0]     win;
  logic [STRIDE_LG-1:0] sub;
  logic                 in_chan;

  assign off     = addr_i - ADDR_W'(CH_BASE);
  assign win     = off[ADDR_W-1:STRIDE_LG];
  assign sub     = off[STRIDE_LG-1:0];
  assign in_chan = (addr_i >= ADDR_W'(CH_BASE)) && (win < WIN_W'(NCH));

  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = win[CH_W-1:0];
    if (addr_i == '0) begin
      sel_o = SEL_RUN;
    end else if (in_chan) begin
      case (sub)
        OFS_CTRL: sel_o = SEL_CTRL;
        OFS_PER:  sel_o = SEL_PER;
        OFS_THR:  sel_o = SEL_THR;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pwmx_regfile.sv
module pwmx_regfile
  import pwmx_pkg::*;
#(
  parameter int NCH   = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  pwmx_sel_e         sel_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    run_o,
  output logic [DIV_W-1:0]  div_o [NCH],
  output logic [CNT_W-1:0]  per_o [NCH],
  output logic [CNT_W-1:0]  thr_o [NCH]
);

  logic [NCH-1:0]    run_q, run_d;
  logic [NCH-1:0]    flag_q, flag_d;
  logic [DIV_W-1:0]  div_q [NCH];
  logic [DIV_W-1:0]  div_d [NCH];
  logic [CNT_W-1:0]  per_q [NCH];
  logic [CNT_W-1:0]  per_d [NCH];
  logic [CNT_W-1:0]  thr_q [NCH];
  logic [CNT_W-1:0]  thr_d [NCH];
  logic [DATA_W-1:0] rd_val, rdata_d, rdata_q;
  logic              wdata_unused;

  assign wdata_unused = ^{wdata_i[DATA_W-1:CTRL_FLAG_BIT+1],
                          wdata_i[CTRL_FLAG_BIT-1:CNT_W]};

  // Next state of the configuration registers
  always_comb begin
    run_d  = run_q;
    flag_d = flag_q;
    for (int c = 0; c < NCH; c++) begin
      div_d[c] = div_q[c];
      per_d[c] = per_q[c];
      thr_d[c] = thr_q[c];
    end
    if (wr_i) begin
      case (sel_i)
        SEL_RUN:  run_d = wdata_i[NCH-1:0];
        SEL_CTRL: begin
          div_d[ch_i]  = wdata_i[DIV_W-1:0];
          flag_d[ch_i] = wdata_i[CTRL_FLAG_BIT];
        end
        SEL_PER:  per_d[ch_i] = wdata_i[CNT_W-1:0];
        SEL_THR:  thr_d[ch_i] = wdata_i[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    case (sel_i)
      SEL_RUN:  rd_val = {{(DATA_W-NCH){1'b0}}, run_q};
      SEL_CTRL: rd_val = {{(DATA_W-CTRL_FLAG_BIT-1){1'b0}}, flag_q[ch_i],
                          {(CTRL_FLAG_BIT-DIV_W){1'b0}}, div_q[ch_i]};
      SEL_PER:  rd_val = {{(DATA_W-CNT_W){1'b0}}, per_q[ch_i]};
      SEL_THR:  rd_val = {{(DATA_W-CNT_W){1'b0}}, thr_q[ch_i]};
      default:  rd_val = '0;
    endcase
    rdata_d = rd_i ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        div_q[c] <= '0;
        per_q[c] <= '0;
        thr_q[c] <= '0;
      end
    end else begin
      run_q   <= run_d;
      flag_q  <= flag_d;
      rdata_q <= rdata_d;
      for (int c = 0; c < NCH; c++) begin
        div_q[c] <= div_d[c];
        per_q[c] <= per_d[c];
        thr_q[c] <= thr_d[c];
      end
    end
  end

  assign rdata_o = rdata_q;
  assign run_o   = run_q;
  assign div_o   = div_q;
  assign per_o   = per_q;
  assign thr_o   = thr_q;

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] aper_o
);

  logic [PRE_W-1:0] pre_q, pre_d, pre_mask;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] aper_q, aper_d;
  logic [CNT_W-1:0] athr_q, athr_d;
  logic [DIV_W-1:0] adiv_q, adiv_d;
  logic             tick;
  logic             wrap;

  assign pre_mask = ~({PRE_W{1'b1}} << adiv_q);
  assign tick     = (pre_q == pre_mask);
  assign wrap     = (cnt_q == aper_q);

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    aper_d = aper_q;
    athr_d = athr_q;
    adiv_d = adiv_q;
    if (!run_i) begin
      // Idle: hold counters cleared and track the programmed setting
      pre_d  = '0;
      cnt_d  = '0;
      aper_d = per_i;
      athr_d = thr_i;
      adiv_d = div_i;
    end else if (tick) begin
      pre_d = '0;
      if (wrap) begin
        cnt_d  = '0;
        aper_d = per_i;
        athr_d = thr_i;
        adiv_d = div_i;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      aper_q <= '0;
      athr_q <= '0;
      adiv_q <= '0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      aper_q <= aper_d;
      athr_q <= athr_d;
      adiv_q <= adiv_d;
    end
  end

  assign pwm_o  = run_i && (cnt_q <= athr_q);
  assign cnt_o  = cnt_q;
  assign aper_o = aper_q;

endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [1:0]         rst_pipe;
  logic               rst_n_int;
  pwmx_sel_e          sel;
  logic [CH_W-1:0]    ch;
  logic [NCH-1:0]     run;
  logic [DIV_W-1:0]   div [NCH];
  logic [CNT_W-1:0]   per [NCH];
  logic [CNT_W-1:0]   thr [NCH];
  logic [NCH*CNT_W-1:0] cnt_flat;
  logic [NCH*CNT_W-1:0] aper_flat;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  pwmx_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr),
    .sel_o  (sel),
    .ch_o   (ch)
  );

  pwmx_regfile #(.NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .sel_i   (sel),
    .ch_i    (ch),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .run_o   (run),
    .div_o   (div),
    .per_o   (per),
    .thr_o   (thr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwmx_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .run_i  (run[g]),
      .div_i  (div[g]),
      .per_i  (per[g]),
      .thr_i  (thr[g]),
      .pwm_o  (pwm_out[g]),
      .cnt_o  (cnt_flat[g*CNT_W +: CNT_W]),
      .aper_o (aper_flat[g*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/pwmx_chk.sv
module pwmx_chk #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NCH-1:0]      run,
  input logic [NCH-1:0]      pwm_out,
  input logic [NCH*13-1:0]   cnt_flat,
  input logic [NCH*13-1:0]   aper_flat
);

  // R10: no read strobe in the previous clock means zero read data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == 32'd0));

  // R2: run word reads never show bits past the channel count
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && ($past(bus_addr) == '0)) |-> ((bus_rdata >> NCH) == 32'd0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // R8: a stopped channel drives low
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |-> !pwm_out[g]);

    // R8: a freshly started channel begins high
    a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[g]) |-> pwm_out[g]);

    // R6: the tick counter never passes the active period
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[g*13 +: 13] <= aper_flat[g*13 +: 13]);

    // R9: a running channel changes its active period only at a cycle start
    a_r9_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && $past(run[g]) && (aper_flat[g*13 +: 13] != $past(aper_flat[g*13 +: 13])))
        |-> (cnt_flat[g*13 +: 13] == 13'd0));
  end

endmodule

bind pwmx_top pwmx_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .run       (run),
  .pwm_out   (pwm_out),
  .cnt_flat  (cnt_flat),
  .aper_flat (aper_flat)
);

// File: tb/pwmx_top_tb.sv
module pwmx_top_tb_top;

  localparam int NCH    = 8;
  localparam int ADDR_W = 12;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit cmp_on = 0;
  string phase = "R1";

  // Reference model state
  int m_run [NCH];
  int m_flag[NCH];
  int m_div [NCH];
  int m_per [NCH];
  int m_thr [NCH];
  int m_pre [NCH];
  int m_cnt [NCH];
  int m_aper[NCH];
  int m_athr[NCH];
  int m_adiv[NCH];

  pwmx_top #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int chan_addr(input int c, input int ofs);
    return 16 + c * 64 + ofs;
  endfunction

  function automatic int model_read(input int a);
    int o, w, s;
    if (a == 0) begin
      int v = 0;
      for (int c = 0; c < NCH; c++) v |= (m_run[c] << c);
      return v;
    end
    if (a < 16) return 0;
    o = a - 16; w = o / 64; s = o % 64;
    if (w >= NCH) return 0;
    if (s == 0)  return (m_flag[w] << 15) | m_div[w];
    if (s == 44) return m_per[w];
    if (s == 48) return m_thr[w];
    return 0;
  endfunction

  function automatic void model_write(input int a, input logic [31:0] d);
    int o, w, s;
    if (a == 0) begin
      for (int c = 0; c < NCH; c++) m_run[c] = d[c];
      return;
    end
    if (a < 16) return;
    o = a - 16; w = o / 64; s = o % 64;
    if (w >= NCH) return;
    if (s == 0) begin m_flag[w] = d[15]; m_div[w] = int'(d[2:0]); end
    else if (s == 44) m_per[w] = int'(d[12:0]);
    else if (s == 48) m_thr[w] = int'(d[12:0]);
  endfunction

  // Model steps at every clock edge from the inputs set at the previous falling edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_run[c] = 0; m_flag[c] = 0; m_div[c] = 0; m_per[c] = 0; m_thr[c] = 0;
        m_pre[c] = 0; m_cnt[c] = 0; m_aper[c] = 0; m_athr[c] = 0; m_adiv[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (m_run[c] == 0) begin
          m_pre[c] = 0; m_cnt[c] = 0;
          m_aper[c] = m_per[c]; m_athr[c] = m_thr[c]; m_adiv[c] = m_div[c];
        end else if (m_pre[c] == (1 << m_adiv[c]) - 1) begin
          m_pre[c] = 0;
          if (m_cnt[c] == m_aper[c]) begin
            m_cnt[c] = 0;
            m_aper[c] = m_per[c]; m_athr[c] = m_thr[c]; m_adiv[c] = m_div[c];
          end else begin
            m_cnt[c]++;
          end
        end else begin
          m_pre[c]++;
        end
      end
      if (bus_wr) model_write(int'(bus_addr), bus_wdata);
    end
  end

  // Every-clock comparison of all outputs against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = (m_run[c] != 0) && (m_cnt[c] <= m_athr[c]);
        chk($sformatf("%s out ch%0d", phase, c), {31'd0, pwm_out[c]}, {31'd0, e});
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic bus_read_chk(input string tag, input int a);
    logic [31:0] e;
    @(negedge clk);
    e = model_read(a);
    bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
    chk($sformatf("%s read %0h", tag, a), bus_rdata, e);
  endtask

  task automatic bus_read_exp(input string tag, input int a, input logic [31:0] e);
    @(negedge clk);
    bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
    chk($sformatf("%s read %0h", tag, a), bus_rdata, e);
  endtask

  // Measures one high time and one full cycle length in clocks
  task automatic measure(input string tag, input int c, input int exp_hi, input int exp_len);
    int hi = 0, lo = 0, guard = 0;
    while (pwm_out[c] && guard < 20000) begin @(negedge clk); guard++; end
    while (!pwm_out[c] && guard < 20000) begin @(negedge clk); guard++; end
    while (pwm_out[c] && guard < 20000) begin @(negedge clk); hi++; guard++; end
    while (!pwm_out[c] && guard < 20000) begin @(negedge clk); lo++; guard++; end
    chk($sformatf("%s high clocks ch%0d", tag, c), hi, exp_hi);
    chk($sformatf("%s cycle clocks ch%0d", tag, c), hi + lo, exp_len);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Watchdog
  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    phase = "R1";
    chk("R1 outputs after reset", {24'd0, pwm_out}, 32'd0);
    chk("R1 read data after reset", bus_rdata, 32'd0);
    bus_read_exp("R1", 0, 32'd0);
    bus_read_exp("R1", chan_addr(0, 0), 32'd0);
    bus_read_exp("R1", chan_addr(3, 44), 32'd0);
    bus_read_exp("R1", chan_addr(7, 48), 32'd0);
    cmp_on = 1;

    // R2: run word readback, upper bits zero
    phase = "R2";
    bus_write(0, 32'hFFFF_FFFF);
    bus_read_exp("R2 all set", 0, 32'h0000_00FF);
    bus_write(0, 32'h0000_00A5);
    bus_read_exp("R2 pattern", 0, 32'h0000_00A5);
    bus_write(0, 32'd0);
    bus_read_exp("R2 cleared", 0, 32'd0);

    // R3: field masks and window placement
    phase = "R3";
    bus_write(chan_addr(5, 0),  32'hFFFF_FFFF);
    bus_write(chan_addr(5, 44), 32'hFFFF_FFFF);
    bus_write(chan_addr(5, 48), 32'hFFFF_E123);
    bus_read_exp("R3 ctrl mask", chan_addr(5, 0), 32'h0000_8007);
    bus_read_exp("R3 period mask", chan_addr(5, 44), 32'h0000_1FFF);
    bus_read_exp("R3 high mask", chan_addr(5, 48), 32'h0000_0123);
    bus_read_exp("R3 neighbour untouched", chan_addr(4, 44), 32'd0);

    // Channel setups
    bus_write(chan_addr(0, 0),  32'h0000_8000);
    bus_write(chan_addr(0, 44), 32'd9);
    bus_write(chan_addr(0, 48), 32'd3);
    bus_write(chan_addr(1, 0),  32'h0000_8002);
    bus_write(chan_addr(1, 44), 32'd4);
    bus_write(chan_addr(1, 48), 32'd1);
    bus_write(chan_addr(2, 0),  32'h0000_8001);
    bus_write(chan_addr(2, 44), 32'd5);
    bus_write(chan_addr(2, 48), 32'd7);
    bus_write(chan_addr(3, 0),  32'h0000_8007);
    bus_write(chan_addr(3, 44), 32'd1);
    bus_write(chan_addr(3, 48), 32'd0);
    bus_read_chk("R3 ctrl ch1", chan_addr(1, 0));
    bus_read_chk("R3 period ch0", chan_addr(0, 44));

    // R4: unmapped writes and reads
    phase = "R4";
    bus_write(4, 32'hFFFF_FFFF);
    bus_write(chan_addr(0, 4), 32'hFFFF_FFFF);
    bus_write(chan_addr(0, 40), 32'hFFFF_FFFF);
    bus_write(chan_addr(8, 0), 32'hFFFF_FFFF);
    bus_write(chan_addr(8, 44), 32'hFFFF_FFFF);
    chk("R4 outputs idle", {24'd0, pwm_out}, 32'd0);
    bus_read_exp("R4 run word", 0, 32'd0);
    bus_read_exp("R4 ch0 ctrl", chan_addr(0, 0), 32'h0000_8000);
    bus_read_exp("R4 ch0 period", chan_addr(0, 44), 32'd9);
    bus_read_exp("R4 ch0 high", chan_addr(0, 48), 32'd3);
    bus_read_exp("R4 hole", chan_addr(0, 4), 32'd0);
    bus_read_exp("R4 beyond", chan_addr(8, 44), 32'd0);

    // R8: start high on enable
    phase = "R8";
    bus_write(0, 32'h0000_000F);
    chk("R8 start high", {28'd0, pwm_out[3:0]}, 32'h0000_000F);

    // R5, R6, R7: waveform shapes
    phase = "R6";
    measure("R6 R7 div1", 0, 4, 10);
    phase = "R5";
    measure("R5 div4", 1, 8, 20);
    phase = "R7";
    repeat (40) begin
      @(negedge clk);
      chk("R7 full-high ch2", {31'd0, pwm_out[2]}, 32'd1);
    end
    phase = "R5";
    measure("R5 div128", 3, 128, 256);

    // R9: reconfigure running channels mid-cycle
    phase = "R9";
    repeat (3) @(negedge clk);
    bus_write(chan_addr(0, 44), 32'd19);
    bus_write(chan_addr(0, 48), 32'd9);
    bus_write(chan_addr(1, 0), 32'h0000_8001);
    repeat (45) @(negedge clk);
    measure("R9 new setting", 0, 10, 20);
    measure("R9 new divider", 1, 4, 10);

    // R8: stop and restart in mid-cycle
    phase = "R8";
    repeat (5) @(negedge clk);
    bus_write(0, 32'h0000_000D);
    chk("R8 stopped low", {31'd0, pwm_out[1]}, 32'd0);
    repeat (30) begin
      @(negedge clk);
      chk("R8 held low", {31'd0, pwm_out[1]}, 32'd0);
    end
    bus_write(0, 32'h0000_000F);
    chk("R8 restart high", {31'd0, pwm_out[1]}, 32'd1);
    bus_read_exp("R2 after restart", 0, 32'h0000_000F);

    // R10: read data idle after a read
    phase = "R10";
    bus_read_exp("R10 data", chan_addr(1, 0), 32'h0000_8001);
    @(negedge clk);
    chk("R10 idle zero", bus_rdata, 32'd0);

    repeat (300) @(negedge clk);
    cmp_on = 0;
    finish_run();
  end

endmodule